// File: doc/BRIEF.md
# Hybrid DC/Triangular Multicarrier PWM Level Generator

This block decides how many submodules to insert in the upper and lower arms of one phase of a five-level modular multilevel converter. On every sample strobe it takes a signed sinusoidal reference sample. It compares the sample against four carriers, stacked one above the other across the reference range. The number of carriers that the reference exceeds is the upper-arm insertion count. The lower arm normally takes the complement, so the phase always holds four submodules inserted.

Each carrier is either a stepped triangular wave or a flat DC threshold at the middle of its band. A mode input chooses the arrangement: all triangular, inner pair DC, or outer pair DC. A separate debug bit makes the lower arm compare against its own carrier set, which is half a period out of phase with the upper set. The sine source, gate drive, dead time and capacitor balancing are outside the block. The outputs feed the balancing stage, which picks which submodules to insert.

Top module: `hybrid_mc_pwm`

## Requirements
- R1: After a synchronous active-low reset, the upper count is 0 and the lower count is 4.
- R2: The upper count equals the number of carriers whose value is strictly below the reference, so it ranges from 0 to 4. A reference of -128 always gives 0.
- R3: Band k (k = 0..3) spans -128+64k up to -125+64k+60, that is base+63. A DC carrier sits at base+32. A reference equal to a carrier does not count that carrier.
- R4: A phase counter starts at 0, advances by one on each strobe and wraps from 99 to 0. The comparison made at a strobe uses the phase value from before that advance. A triangular carrier in band k equals base + (t*63)/50, where t = phase for phase <= 50 and t = 100 - phase otherwise.
- R5: mode_sel[1:0] selects the carrier arrangement. 0 makes all four carriers triangular. 1 makes bands 1 and 2 DC and bands 0 and 3 triangular. 2 makes bands 0 and 3 DC and bands 1 and 2 triangular. 3 behaves like 0.
- R6: With mode_sel[2] = 0, the lower count equals 4 minus the upper count, so the two counts sum to 4.
- R7: With mode_sel[2] = 1, the lower count equals 4 minus the number of lower-set carriers below the reference. The lower-set triangular carriers use phase (phase+50) mod 100. The arrangement and DC levels of the lower set match those of the upper set.
- R8: Both counts are registered and change only on a clock edge where the sample strobe is high. Reference and mode changes at any other time have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe marking a valid reference sample |
| ref_sample | input | 8 | Signed two's-complement reference sample |
| mode_sel | input | 3 | [1:0] carrier arrangement, [2] independent lower-arm comparison |
| upper_cnt | output | 3 | Submodules to insert in the upper arm |
| lower_cnt | output | 3 | Submodules to insert in the lower arm |

## Verification
On every cycle the assertions check the following invariants. The phase counter stays in range and advances by one only on a strobe. The counts hold between strobes. The counts sum to four outside debug mode. Every carrier stays inside its own band. A minimum reference yields zero insertions. The exact count for a given phase, arrangement and reference depends on the carrier shape. So do the strict-equality corner at a DC level, the peak of the top triangle and the half-period offset of the lower set. Only the bench's scoreboard shows these, because it models the carriers independently and sweeps many references over whole carrier periods in every mode.

// File: rtl/hmc_pkg.sv
// Package: shared types for the hybrid multicarrier PWM level generator.
// Assumes the carrier arrangement code is two bits wide.
package hmc_pkg;

    // Carrier arrangement selected by the low mode bits.
    typedef enum logic [1:0] {
        ARR_ALL_TRI = 2'd0,   // every band triangular
        ARR_MID_DC  = 2'd1,   // inner bands flat, outer bands triangular
        ARR_OUT_DC  = 2'd2,   // outer bands flat, inner bands triangular
        ARR_RSVD    = 2'd3    // treated as all triangular
    } arr_e;

endpackage

// File: rtl/hmc_phase_ctr.sv
// Module: hmc_phase_ctr
// Steps the shared carrier phase once per sample strobe. The phase runs
// over STEPS positions and wraps to zero. A second output gives the phase
// half a period later, for the shifted carrier set.
// Assumes STEPS is even.
module hmc_phase_ctr #(
    parameter int STEPS = 100,
    localparam int PH_W = $clog2(STEPS),
    localparam int HALF = STEPS / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    output logic [PH_W-1:0] phase,
    output logic [PH_W-1:0] phase_shift
);

    // Advance the phase on each strobe, wrapping at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (stb) begin
            phase <= (phase == PH_W'(STEPS - 1)) ? '0 : phase + 1'b1;
        end
    end

    // Derive the phase of the carrier set that runs half a period later.
    always_comb begin
        phase_shift = (phase >= PH_W'(HALF)) ? phase - PH_W'(HALF)
                                             : phase + PH_W'(HALF);
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PH_W'(STEPS));                                                      // R4
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> phase == (($past(phase) == PH_W'(STEPS - 1)) ? '0 : $past(phase) + 1'b1)); // R4
    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(phase));                                                   // R4

endmodule

// File: rtl/hmc_carrier_bank.sv
// Module: hmc_carrier_bank
// Builds one set of N_SM carriers, stacked in equal bands across the signed
// reference range. Each band is either a symmetric stepped triangle or a flat
// level at the band middle, as the arrangement code selects.
// Assumes N_SM >= 2 and a power-of-two reference range that N_SM divides.
module hmc_carrier_bank
    import hmc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_SM   = 4,
    parameter int STEPS  = 100,
    localparam int PH_W  = $clog2(STEPS),
    localparam int HALF  = STEPS / 2,
    localparam int BAND  = (2 ** DATA_W) / N_SM
) (
    input  logic [PH_W-1:0]              phase,
    input  arr_e                         arr,
    output logic [N_SM-1:0][DATA_W-1:0]  carriers
);

    logic [PH_W-1:0] tri_pos;

    // Fold the phase into a rising-then-falling triangle position, 0..HALF.
    always_comb begin
        tri_pos = (phase <= PH_W'(HALF)) ? phase : PH_W'(STEPS) - phase;
    end

    for (genvar k = 0; k < N_SM; k++) begin : g_band
        localparam int BASE  = -(2 ** (DATA_W - 1)) + k * BAND;
        localparam bit INNER = (k != 0) && (k != N_SM - 1);

        logic is_dc;
        int   level;

        // Decide whether this band is a flat level under the chosen arrangement.
        always_comb begin
            is_dc = ((arr == ARR_MID_DC) && INNER) || ((arr == ARR_OUT_DC) && !INNER);
        end

        // Form the carrier value: band middle when flat, scaled ramp otherwise.
        always_comb begin
            level = is_dc ? BASE + BAND / 2
                          : BASE + (int'(tri_pos) * (BAND - 1)) / HALF;
        end

        assign carriers[k] = DATA_W'(level);
    end

endmodule

// File: rtl/hmc_level_count.sv
// Module: hmc_level_count
// Counts how many carriers lie strictly below the signed reference.
// Assumes the carriers are two's-complement values of the reference width.
module hmc_level_count #(
    parameter int DATA_W = 8,
    parameter int N_SM   = 4,
    localparam int CNT_W = $clog2(N_SM + 1)
) (
    input  logic signed [DATA_W-1:0]     ref_val,
    input  logic [N_SM-1:0][DATA_W-1:0]  carriers,
    output logic [CNT_W-1:0]             count
);

    // Add one for each carrier the reference strictly exceeds.
    always_comb begin
        count = '0;
        for (int k = 0; k < N_SM; k++) begin
            if (ref_val > $signed(carriers[k])) begin
                count = count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hybrid_mc_pwm.sv
// Module: hybrid_mc_pwm (top)
// Per-phase level generator for a modular multilevel converter. A reference
// sample is compared against an upper carrier set, and optionally against a
// half-period shifted lower set. The results become registered insertion
// counts for both arms.
// Assumes sample_stb is high for one cycle per reference sample. mode_sel is
// read on the same edge.
module hybrid_mc_pwm
    import hmc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_SM   = 4,
    parameter int STEPS  = 100,
    localparam int PH_W  = $clog2(STEPS),
    localparam int CNT_W = $clog2(N_SM + 1),
    localparam int BAND  = (2 ** DATA_W) / N_SM
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic signed [DATA_W-1:0] ref_sample,
    input  logic [2:0]               mode_sel,
    output logic [CNT_W-1:0]         upper_cnt,
    output logic [CNT_W-1:0]         lower_cnt
);

    logic [PH_W-1:0]             phase, phase_shift;
    logic [N_SM-1:0][DATA_W-1:0] car_up, car_lo;
    logic [CNT_W-1:0]            cnt_up, cnt_lo;
    arr_e                        arr;
    logic                        split_lower;

    // Split the mode input into the arrangement code and the debug bit.
    always_comb begin
        arr         = arr_e'(mode_sel[1:0]);
        split_lower = mode_sel[2];
    end

    hmc_phase_ctr #(.STEPS(STEPS)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb         (sample_stb),
        .phase       (phase),
        .phase_shift (phase_shift)
    );

    hmc_carrier_bank #(.DATA_W(DATA_W), .N_SM(N_SM), .STEPS(STEPS)) u_bank_up (
        .phase    (phase),
        .arr      (arr),
        .carriers (car_up)
    );

    hmc_carrier_bank #(.DATA_W(DATA_W), .N_SM(N_SM), .STEPS(STEPS)) u_bank_lo (
        .phase    (phase_shift),
        .arr      (arr),
        .carriers (car_lo)
    );

    hmc_level_count #(.DATA_W(DATA_W), .N_SM(N_SM)) u_cnt_up (
        .ref_val  (ref_sample),
        .carriers (car_up),
        .count    (cnt_up)
    );

    hmc_level_count #(.DATA_W(DATA_W), .N_SM(N_SM)) u_cnt_lo (
        .ref_val  (ref_sample),
        .carriers (car_lo),
        .count    (cnt_lo)
    );

    // Capture both arm counts on the sample strobe; lower is the complement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_cnt <= '0;
            lower_cnt <= CNT_W'(N_SM);
        end else if (sample_stb) begin
            upper_cnt <= cnt_up;
            lower_cnt <= split_lower ? CNT_W'(N_SM) - cnt_lo
                                     : CNT_W'(N_SM) - cnt_up;
        end
    end

    for (genvar k = 0; k < N_SM; k++) begin : g_chk
        localparam int LO = -(2 ** (DATA_W - 1)) + k * BAND;
        localparam int HI = LO + BAND - 1;
        AST_CARRIER_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(car_up[k]) >= LO) && ($signed(car_up[k]) <= HI)
            && ($signed(car_lo[k]) >= LO) && ($signed(car_lo[k]) <= HI));         // R3
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(upper_cnt) && $stable(lower_cnt));                 // R8
    AST_ARM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb && !mode_sel[2] |=> (upper_cnt + lower_cnt) == CNT_W'(N_SM));   // R6
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        upper_cnt <= CNT_W'(N_SM) && lower_cnt <= CNT_W'(N_SM));                   // R2
    AST_MIN_REF: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb && ref_sample == -(2 ** (DATA_W - 1)) |=> upper_cnt == '0);    // R2

endmodule

// File: tb/hybrid_mc_pwm_tb.sv
// Scoreboard bench: the driver computes expected counts from its own carrier
// model and queues them; the monitor compares after each strobe edge and
// checks that the outputs hold between strobes.
module hybrid_mc_pwm_tb;

    typedef struct {
        int    up;
        int    lo;
        string tag_up;
        string tag_lo;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_stb = 1'b0;
    logic signed [7:0] ref_sample = '0;
    logic [2:0]        mode_sel = '0;
    logic [2:0]        upper_cnt, lower_cnt;

    int   errors = 0;
    int   checks = 0;
    int   mph = 0;
    logic fired = 1'b0;
    logic have_last = 1'b0;
    exp_t last;
    exp_t sb[$];
    int unsigned seed = 32'h1234_5678;

    hybrid_mc_pwm u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .ref_sample (ref_sample),
        .mode_sel   (mode_sel),
        .upper_cnt  (upper_cnt),
        .lower_cnt  (lower_cnt)
    );

    always #4 clk = ~clk;

    function automatic int carrier(int k, int ph, int arr);
        int  base = -128 + 64 * k;
        bit  dc   = (arr == 1 && (k == 1 || k == 2)) || (arr == 2 && (k == 0 || k == 3));
        int  t    = (ph <= 50) ? ph : 100 - ph;
        return dc ? base + 32 : base + (t * 63) / 50;
    endfunction

    function automatic int above(int r, int ph, int arr);
        int n = 0;
        for (int k = 0; k < 4; k++) if (r > carrier(k, ph, arr)) n++;
        return n;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic sample(int r, int mode, string tag, int gap);
        exp_t e;
        int   arr = mode & 3;
        @(negedge clk);
        ref_sample = 8'(r);
        mode_sel   = 3'(mode);
        sample_stb = 1'b1;
        e.up = above(r, mph, arr);
        if (mode[2]) begin
            e.lo     = 4 - above(r, (mph + 50) % 100, arr);
            e.tag_lo = "R7";
        end else begin
            e.lo     = 4 - e.up;
            e.tag_lo = "R6";
        end
        e.tag_up = tag;
        sb.push_back(e);
        mph = (mph + 1) % 100;
        @(negedge clk);
        sample_stb = 1'b0;
        for (int i = 0; i < gap; i++) begin
            ref_sample = 8'($urandom(seed));
            mode_sel   = 3'(i);
            @(negedge clk);
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[23:16]));
    endfunction

    // Record whether the latest edge carried a strobe.
    always @(posedge clk) fired <= sample_stb;

    // Monitor: compare after strobe edges, check hold otherwise.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && fired) begin
                if (sb.size() == 0) begin
                    check("R8", "unexpected update", 1, 0);
                end else begin
                    last = sb.pop_front();
                    have_last = 1'b1;
                    check(last.tag_up, "upper_cnt", int'(upper_cnt), last.up);
                    check(last.tag_lo, "lower_cnt", int'(lower_cnt), last.lo);
                end
            end else if (rst_n && have_last) begin
                check("R8", "upper hold", int'(upper_cnt), last.up);
                check("R8", "lower hold", int'(lower_cnt), last.lo);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        check("WDOG", "watchdog expired", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset upper", int'(upper_cnt), 0);
        check("R1", "reset lower", int'(lower_cnt), 4);

        // R4: all-triangular carriers over two full periods.
        for (int i = 0; i < 200; i++) sample(rnd(), 0, "R4", i % 3);
        // R2: extremes of the reference, including the top triangle peak.
        for (int i = 0; i < 100; i++) sample((i % 2) ? 127 : -128, 0, "R2", 0);

        // R5: inner bands flat, with R3 equality corners at band 1 middle.
        sample(-32, 1, "R3", 1);
        sample(-31, 1, "R3", 1);
        sample(32, 1, "R3", 0);
        sample(33, 1, "R3", 0);
        for (int i = 0; i < 100; i++) sample(rnd(), 1, "R5", i % 2);

        // R5: outer bands flat, R3 corners at bottom and top band middles.
        sample(-96, 2, "R3", 0);
        sample(-95, 2, "R3", 0);
        sample(96, 2, "R3", 0);
        sample(97, 2, "R3", 0);
        for (int i = 0; i < 100; i++) sample(rnd(), 2, "R5", i % 2);

        // R5: reserved code behaves as all triangular.
        for (int i = 0; i < 60; i++) sample(rnd(), 3, "R5", 0);

        // R7: independent lower-arm comparison in each arrangement.
        for (int m = 4; m < 7; m++) begin
            for (int i = 0; i < 110; i++) sample(rnd(), m, "R7", i % 2);
        end

        repeat (4) @(negedge clk);
        check("R8", "scoreboard drained", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule